// File: doc/BRIEF.md
# Three-Port Latched Bus Crossbar

This block routes 9-bit words between three ports, A, B and C, in any direction. Each destination port owns a private capture stage for each of the three sources, so a word arriving on any port can be caught and presented on either of the other two ports. A destination may also pick its own source, which reads back what that port itself presented, for self-check. The top bit of every word is a parity bit. A parity-flip control lets diagnostics corrupt that bit on purpose, but only on traffic that leaves port C for A or B.

Each capture stage has its own enable. While the enable is high the stage passes its input straight through. While it is low, the stage keeps the word it took at the last clock edge with the enable high. Every destination has a 2-bit source select and its own drive enable. When the drive enable is low the port reports a high-impedance flag and presents zeros in place of a data value. Real tri-state pins are split into separate input, output and flag signals.

Top module: `xbar3_top`

## Requirements
- R1: After synchronous reset every capture stage and every hold register holds zero, so with all stage enables low and a drive enable high, each port outputs 0 for every select value.
- R2: While the stage enable `path_le[d][s]` is high, the word selected from source s appears at destination d in the same cycle as `port_in[s]`.
- R3: While `path_le[d][s]` is low, the stage keeps the value of `port_in[s]` sampled at the last rising clock edge at which that enable was high, and changes on `port_in[s]` do not reach destination d.
- R4: The select encoding for each destination is 00 = source A (index 0), 01 = source B (index 1), 10 = source C (index 2). Any source can be routed to any other destination.
- R5: A destination whose select names its own index outputs its own captured input (readback). Readback on C is never parity-flipped.
- R6: When `par_inv` is high, bit 8 is inverted on the C-to-A and C-to-B paths only. Bits 0 to 7, every other path and C-to-C readback are unchanged.
- R7: Select 11 keeps the destination at the value it presented at the last rising edge where its select was not 11, and later changes to inputs, enables or `par_inv` have no effect on it.
- R8: With `port_oe[d]` low, `port_hiz[d]` is 1 and `port_out[d]` is all zeros. With it high, `port_hiz[d]` is 0. The drive enable has no effect on capture stages or hold registers.
- R9: Each stage enable affects only its own stage (destination d, source s at bit d*3+s of `path_le`). Raising one does not disturb any other destination or stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_in | input | 27 | Input words, port p at bits p*9+8 : p*9 (A=0, B=1, C=2) |
| path_le | input | 9 | Stage enables, destination d and source s at bit d*3+s |
| port_oe | input | 3 | Drive enable per port, active high |
| port_sel | input | 6 | Source select per destination, port p at bits p*2+1 : p*2 |
| par_inv | input | 1 | Invert parity bit on C-to-A and C-to-B paths |
| port_out | output | 27 | Output words, same packing as port_in |
| port_hiz | output | 3 | High-impedance flag per port |

## Verification
Transparent routing, readback, parity flipping and drive gating are combinational, so they are due in the same cycle as the inputs that cause them. Captured words and hold values become visible from the first cycle after the rising edge that stores them. The bench changes inputs 1 ns after each rising edge and samples at the falling edge, when both kinds of result have settled. At that point its behavioural model compares every port, and only after the comparison does it advance its own state to what the coming edge stores.

// File: rtl/xbar3_pkg.sv
package xbar3_pkg;

  // Word width and port count used when the top is built with defaults
  localparam int unsigned XB_W     = 9;
  localparam int unsigned XB_NPORT = 3;

  // Parity flip applies only when leaving the last port (C) for another port
  function automatic bit parity_path(input int src, input int dst, input int nport);
    return (src == nport - 1) && (dst != src);
  endfunction

  // Flip the top bit of a word when asked to
  function automatic logic [XB_W-1:0] flip_top(input logic [XB_W-1:0] v, input logic flip);
    logic [XB_W-1:0] m;
    m = '0;
    m[XB_W-1] = flip;
    return v ^ m;
  endfunction

endpackage

// File: rtl/xbar3_path_latch.sv
module xbar3_path_latch #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_o
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)     held_q <= '0;
    else if (le) held_q <= d;
  end

  // Transparent while enabled, holding otherwise
  assign q_o = le ? d : held_q;

endmodule

// File: rtl/xbar3_dest_port.sv
module xbar3_dest_port #(
  parameter int unsigned W     = 9,
  parameter int unsigned NPORT = 3,
  parameter int unsigned SELW  = 2,
  parameter int unsigned DST   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SELW-1:0]             sel,
  input  logic                        oe,
  input  logic                        par_inv,
  input  logic [NPORT-1:0][W-1:0]     lat_val,
  output logic [W-1:0]                port_out,
  output logic                        port_hiz,
  output logic [W-1:0]                drive_val
);

  logic [NPORT-1:0][W-1:0] path_val;
  logic [W-1:0]            route_val;
  logic [W-1:0]            hold_q;
  logic                    use_hold;

  function automatic logic [W-1:0] path_xform(input logic [W-1:0] v, input logic flip);
    logic [W-1:0] m;
    m = '0;
    m[W-1] = flip;
    return v ^ m;
  endfunction

  for (genvar s = 0; s < NPORT; s++) begin : g_path
    localparam bit FLIPS = xbar3_pkg::parity_path(s, DST, NPORT);
    if (FLIPS) begin : g_flip
      assign path_val[s] = path_xform(lat_val[s], par_inv);
    end else begin : g_pass
      assign path_val[s] = lat_val[s];
    end
  end

  assign use_hold = (int'(sel) >= NPORT);

  always_comb begin
    route_val = '0;
    for (int s = 0; s < NPORT; s++) begin
      if (int'(sel) == s) route_val = path_val[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            hold_q <= '0;
    else if (!use_hold) hold_q <= route_val;
  end

  assign drive_val = use_hold ? hold_q : route_val;
  assign port_out  = oe ? drive_val : '0;
  assign port_hiz  = ~oe;

endmodule

// File: rtl/xbar3_top.sv
module xbar3_top #(
  parameter int unsigned W     = 9,
  parameter int unsigned NPORT = 3,
  parameter int unsigned SELW  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORT-1:0][W-1:0]       port_in,
  input  logic [NPORT-1:0][NPORT-1:0]   path_le,
  input  logic [NPORT-1:0]              port_oe,
  input  logic [NPORT-1:0][SELW-1:0]    port_sel,
  input  logic                          par_inv,
  output logic [NPORT-1:0][W-1:0]       port_out,
  output logic [NPORT-1:0]              port_hiz
);

  // Stage outputs per destination, per source
  logic [NPORT-1:0][NPORT-1:0][W-1:0] lat_val;
  // Value each destination presents before drive gating
  logic [NPORT-1:0][W-1:0]            drive_val;

  for (genvar d = 0; d < NPORT; d++) begin : g_dst
    for (genvar s = 0; s < NPORT; s++) begin : g_src
      xbar3_path_latch #(.W(W)) lat_i (
        .clk (clk),
        .rst (rst),
        .le  (path_le[d][s]),
        .d   (port_in[s]),
        .q_o (lat_val[d][s])
      );
    end

    xbar3_dest_port #(.W(W), .NPORT(NPORT), .SELW(SELW), .DST(d)) dst_i (
      .clk       (clk),
      .rst       (rst),
      .sel       (port_sel[d]),
      .oe        (port_oe[d]),
      .par_inv   (par_inv),
      .lat_val   (lat_val[d]),
      .port_out  (port_out[d]),
      .port_hiz  (port_hiz[d]),
      .drive_val (drive_val[d])
    );
  end

endmodule

// File: rtl/xbar3_chk.sv
module xbar3_chk #(
  parameter int unsigned W     = 9,
  parameter int unsigned NPORT = 3,
  parameter int unsigned SELW  = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NPORT-1:0][W-1:0]       port_in,
  input logic [NPORT-1:0][NPORT-1:0]   path_le,
  input logic [NPORT-1:0]              port_oe,
  input logic [NPORT-1:0][SELW-1:0]    port_sel,
  input logic                          par_inv,
  input logic [NPORT-1:0][W-1:0]       port_out,
  input logic [NPORT-1:0]              port_hiz,
  input logic [NPORT-1:0][NPORT-1:0][W-1:0] lat_val
);

  localparam logic [SELW-1:0] SEL_HOLD = '1;

  for (genvar d = 0; d < NPORT; d++) begin : g_d
    AST_HIZ_GATING: assert property (@(posedge clk) disable iff (rst)
      !port_oe[d] |-> (port_hiz[d] && port_out[d] == '0)); // R8

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
      (port_sel[d] == SEL_HOLD && $past(port_sel[d]) == SEL_HOLD && !$past(rst)
       && port_oe[d] && $past(port_oe[d])) |-> $stable(port_out[d])); // R7

    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
      (port_oe[d] && int'(port_sel[d]) == d && path_le[d][d]) |-> port_out[d] == port_in[d]); // R5

    for (genvar s = 0; s < NPORT; s++) begin : g_s
      AST_LOW_BITS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (port_oe[d] && int'(port_sel[d]) == s && path_le[d][s])
        |-> port_out[d][W-2:0] == port_in[s][W-2:0]); // R4

      AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!path_le[d][s] && !$past(path_le[d][s]) && !$past(rst)) |-> $stable(lat_val[d][s])); // R3
    end

    if (d != NPORT - 1) begin : g_par
      AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (rst)
        (port_oe[d] && int'(port_sel[d]) == NPORT - 1 && path_le[d][NPORT-1])
        |-> port_out[d][W-1] == (port_in[NPORT-1][W-1] ^ par_inv)); // R6
    end
  end

endmodule

bind xbar3_top xbar3_chk #(.W(W), .NPORT(NPORT), .SELW(SELW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .port_in  (port_in),
  .path_le  (path_le),
  .port_oe  (port_oe),
  .port_sel (port_sel),
  .par_inv  (par_inv),
  .port_out (port_out),
  .port_hiz (port_hiz),
  .lat_val  (lat_val)
);

// File: tb/xbar3_top_tb_top.sv
module xbar3_top_tb_top;

  localparam int W = 9;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0][W-1:0]  port_in  = '0;
  logic [NP-1:0][NP-1:0] path_le  = '0;
  logic [NP-1:0]         port_oe  = '0;
  logic [NP-1:0][1:0]    port_sel = '0;
  logic                  par_inv  = 1'b0;
  logic [NP-1:0][W-1:0]  port_out;
  logic [NP-1:0]         port_hiz;

  int checks = 0;
  int errors = 0;
  string ph_tag = "";
  bit done = 1'b0;

  // Behavioural model state: captured words per (dst, src) and hold words
  logic [W-1:0] m_cap [NP][NP];
  logic [W-1:0] m_hold [NP];

  always #4 clk = ~clk;

  xbar3_top dut_i (
    .clk(clk), .rst(rst), .port_in(port_in), .path_le(path_le),
    .port_oe(port_oe), .port_sel(port_sel), .par_inv(par_inv),
    .port_out(port_out), .port_hiz(port_hiz)
  );

  function automatic string tag_for(int d);
    if (ph_tag != "") return ph_tag;
    if (!port_oe[d]) return "R8";
    if (port_sel[d] == 2'd3) return "R7";
    if (int'(port_sel[d]) == d) return "R5";
    if (port_sel[d] == 2'd2) return "R6";
    return "R4";
  endfunction

  // Word a source hands to a destination this cycle, before selection
  function automatic logic [W-1:0] model_path(int d, int s);
    logic [W-1:0] v;
    v = path_le[d][s] ? port_in[s] : m_cap[d][s];
    if (s == 2 && d != 2 && par_inv) v[W-1] = ~v[W-1];
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      foreach (m_cap[i, j]) m_cap[i][j] = '0;
      foreach (m_hold[i]) m_hold[i] = '0;
    end else begin
      logic [W-1:0] drv [NP];
      for (int d = 0; d < NP; d++) begin
        logic [W-1:0] e_out;
        logic e_hiz;
        drv[d] = (port_sel[d] == 2'd3) ? m_hold[d] : model_path(d, int'(port_sel[d]));
        e_out = port_oe[d] ? drv[d] : '0;
        e_hiz = ~port_oe[d];
        checks++;
        if (port_out[d] !== e_out || port_hiz[d] !== e_hiz) begin
          errors++;
          $display("FAIL %s port %0d out=%h hiz=%b expected out=%h hiz=%b",
                   tag_for(d), d, port_out[d], port_hiz[d], e_out, e_hiz);
        end
      end
      // Advance the model to what the coming edge stores
      for (int d = 0; d < NP; d++) begin
        if (port_sel[d] != 2'd3) m_hold[d] = drv[d];
        for (int s = 0; s < NP; s++)
          if (path_le[d][s]) m_cap[d][s] = port_in[s];
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rand_inputs();
    for (int p = 0; p < NP; p++) port_in[p] = W'($urandom);
  endtask

  initial begin
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    // R1: everything zero after reset, for every select value
    ph_tag = "R1";
    port_oe = '1;
    rand_inputs();
    for (int v = 0; v < 4; v++) begin
      for (int d = 0; d < NP; d++) port_sel[d] = 2'(v);
      cyc();
    end
    ph_tag = "";

    // Sweep all source/destination pairs, parity flip off and on
    for (int s = 0; s < NP; s++) begin
      for (int d = 0; d < NP; d++) begin
        for (int inv = 0; inv < 2; inv++) begin
          ph_tag = "R2";
          path_le = '0;
          path_le[d][s] = 1'b1;
          rand_inputs();
          port_in[s][W-1] = 1'b1;
          port_sel[d] = 2'(s);
          port_oe[d] = 1'b1;
          par_inv = 1'(inv);
          cyc();
          ph_tag = "";          // routing R4, readback R5, parity R6
          rand_inputs();
          cyc();
          ph_tag = "R3";
          path_le[d][s] = 1'b0;
          rand_inputs();
          cyc(2);
          ph_tag = "R7";
          port_sel[d] = 2'd3;
          par_inv = ~par_inv;
          path_le = '1;
          rand_inputs();
          cyc(2);
          ph_tag = "R8";
          port_oe[d] = 1'b0;
          cyc();
          port_oe[d] = 1'b1;
          path_le = '0;
          cyc();
        end
      end
    end

    // R9: one enable raised, all others idle
    ph_tag = "R9";
    path_le = '0;
    port_oe = '1;
    for (int d = 0; d < NP; d++) port_sel[d] = 2'(NP - 1 - d);
    for (int k = 0; k < NP * NP; k++) begin
      path_le = '0;
      path_le[k / NP][k % NP] = 1'b1;
      rand_inputs();
      cyc(2);
    end
    ph_tag = "";

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      rand_inputs();
      path_le = NP*NP'($urandom);
      port_oe = NP'($urandom);
      for (int d = 0; d < NP; d++) port_sel[d] = 2'($urandom);
      par_inv = 1'($urandom);
      cyc();
    end

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule